// File: doc/BRIEF.md
# Register-Mapped Serial Port with Character Queues

This block is an asynchronous serial port on a plain 32-bit register bus. Software writes characters into an eight-deep transmit queue, and a shifter sends them as frames. Each frame is a low start bit, eight data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. A deserializer samples the receive line on a 16x oversampled clock. It pushes each character, together with its parity and framing error flags, into an eight-deep receive queue that software drains by reading the receive data register.

Each register has three write views. The base address replaces the register, the address +0x4 clears the bits written as one, and the address +0x8 sets the bits written as one. A loopback mode feeds the serial output back to the receiver and holds the external line idle. A break control forces the line low. There are three single-cycle pulse outputs: one for received data, one for the transmit path and one for line faults.

Top module: `uart_mmio`

## Requirements
- R1: After reset the mode register (0x00) reads 0, the status register (0x10) reads 0x0100 (only bit 8 set), the divisor register (0x40) reads 0, and txd_o is high.
- R2: A write to a register's base address replaces its writable bits. A write to base+0x4 clears only the bits written as 1, and a write to base+0x8 sets only the bits written as 1. Bits that cannot be written read as 0. The writable mode bits are 15, 6, 2, 1 and 0.
- R3: The transmit queue holds 8 characters. Status bit 9 reads 1 while it is full, and a write to 0x20 while it is full is dropped.
- R4: A transmitted frame is a start bit at 0, then the data bits least significant bit first, then the stop bits at 1. Each bit lasts 16*(divisor+1) clock cycles. Transmission needs mode bit 15 (enable) and status bit 10 (transmit enable).
- R5: Mode bits [2:1] select the parity: 00 none, 01 even, 10 odd. The parity bit follows the eighth data bit.
- R6: Mode bit 0 set gives two stop bits, so a queued second frame starts 11 bit times after the first one without parity. With the bit clear it starts after 10 bit times.
- R7: With mode bit 6 set the serial output drives the receiver internally, and txd_o stays high.
- R8: While status bit 11 is set, txd_o is low.
- R9: Status bit 0 reads 1 while a received character is waiting. A read of 0x30 returns it in bits [7:0] and removes it. With status bits [7:6] at 00, irq_rx_o pulses once when the first character arrives.
- R10: Status bits 3 (parity error) and 2 (framing error) describe the character at the head of the receive queue and change when it is read. irq_fault_o pulses when a character arrives with an error.
- R11: A character that arrives while the receive queue is full is lost. It sets status bit 1 (overrun) and pulses irq_fault_o. Clearing a set bit 1 empties the receive queue.
- R12: With status bit 15 clear, irq_tx_o pulses once each time the transmit queue and the shifter both become empty. Status bit 8 shows that condition.
- R13: With status bit 12 (receive enable) clear, incoming frames are ignored. With mode bit 15 clear, queued characters are not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the access |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_rx_o | output | 1 | Receive-level pulse |
| irq_tx_o | output | 1 | Transmit-condition pulse |
| irq_fault_o | output | 1 | Line-error or overrun pulse |

## Verification
The bench samples the external line at the middle of each bit. A wrong divisor relation, bit order or parity sense therefore shows up as a wrong sampled bit, and a miscounted stop length puts the next start bit at the wrong time. It sends a bad-parity character followed by a good one, so error flags that stick to the last arrival instead of following the queue head are caught. A ninth character into a full receive queue must raise overrun, and clearing overrun must leave nothing to read. Nine writes into the transmit queue must come back through loopback as exactly eight characters, so an off-by-one depth or a queue that accepts writes while full is exposed.

// File: rtl/uart_pkg.sv
package uart_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_RSV  = 2'b11
  } parity_e;

  typedef enum logic [2:0] {
    F_IDLE, F_START, F_DATA, F_PAR, F_STOP
  } frame_e;

  localparam logic [3:0] REG_MODE = 4'h0;
  localparam logic [3:0] REG_STAT = 4'h1;
  localparam logic [3:0] REG_TXD  = 4'h2;
  localparam logic [3:0] REG_RXD  = 4'h3;
  localparam logic [3:0] REG_BRG  = 4'h4;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_CLR = 2'd1;
  localparam logic [1:0] OP_SET = 2'd2;

  function automatic logic par_on(parity_e p);
    return (p == PAR_EVEN) || (p == PAR_ODD);
  endfunction

  function automatic logic par_bit(logic [7:0] d, parity_e p);
    return (p == PAR_ODD) ? ~^d : ^d;
  endfunction
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic [CW-1:0]    count_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign dout_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx import uart_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       on_i,
  input  logic       en_i,
  input  logic       tick_i,
  input  parity_e    par_i,
  input  logic       stop2_i,
  input  logic       fifo_empty_i,
  input  logic [7:0] fifo_data_i,
  output logic       fifo_pop_o,
  output logic       ser_o,
  output logic       busy_o
);
  frame_e st_q;
  logic [3:0] sub_q;
  logic [2:0] idx_q;
  logic [7:0] sh_q;
  logic pbit_q, second_q;

  assign fifo_pop_o = on_i && en_i && (st_q == F_IDLE) && !fifo_empty_i;
  assign busy_o = (st_q != F_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= F_IDLE; sub_q <= '0; idx_q <= '0; sh_q <= '0;
      pbit_q <= 1'b0; second_q <= 1'b0;
    end else if (!on_i) begin
      st_q <= F_IDLE; sub_q <= '0;
    end else if (fifo_pop_o) begin
      st_q <= F_START; sub_q <= '0; idx_q <= '0; second_q <= 1'b0;
      sh_q <= fifo_data_i;
      pbit_q <= par_bit(fifo_data_i, par_i);
    end else if (tick_i && st_q != F_IDLE) begin
      sub_q <= sub_q + 1'b1;
      if (sub_q == 4'hF) begin
        unique case (st_q)
          F_START: st_q <= F_DATA;
          F_DATA: begin
            sh_q  <= {1'b0, sh_q[7:1]};
            idx_q <= idx_q + 1'b1;
            if (idx_q == 3'd7) st_q <= par_on(par_i) ? F_PAR : F_STOP;
          end
          F_PAR: st_q <= F_STOP;
          F_STOP: begin
            if (stop2_i && !second_q) second_q <= 1'b1;
            else st_q <= F_IDLE;
          end
          default: st_q <= F_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (st_q)
      F_START: ser_o = 1'b0;
      F_DATA:  ser_o = sh_q[0];
      F_PAR:   ser_o = pbit_q;
      default: ser_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx import uart_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       on_i,
  input  logic       en_i,
  input  logic       tick_i,
  input  parity_e    par_i,
  input  logic       ser_i,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       perr_o,
  output logic       ferr_o
);
  frame_e st_q;
  logic [3:0] sub_q;
  logic [2:0] idx_q;
  logic [7:0] sh_q;
  logic perr_q, done_q, ferr_q;

  assign done_o = done_q;
  assign data_o = sh_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= F_IDLE; sub_q <= '0; idx_q <= '0; sh_q <= '0;
      perr_q <= 1'b0; ferr_q <= 1'b0; done_q <= 1'b0;
    end else if (!on_i || !en_i) begin
      st_q <= F_IDLE; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        sub_q <= sub_q + 1'b1;
        unique case (st_q)
          F_IDLE: begin
            sub_q <= '0;
            if (!ser_i) st_q <= F_START;
          end
          F_START: if (sub_q == 4'd7) begin
            sub_q <= '0; idx_q <= '0; perr_q <= 1'b0;
            st_q  <= ser_i ? F_IDLE : F_DATA;
          end
          F_DATA: if (sub_q == 4'hF) begin
            sh_q  <= {ser_i, sh_q[7:1]};
            idx_q <= idx_q + 1'b1;
            if (idx_q == 3'd7) st_q <= par_on(par_i) ? F_PAR : F_STOP;
          end
          F_PAR: if (sub_q == 4'hF) begin
            perr_q <= ser_i ^ par_bit(sh_q, par_i);
            st_q   <= F_STOP;
          end
          F_STOP: if (sub_q == 4'hF) begin
            ferr_q <= !ser_i;
            done_q <= 1'b1;
            st_q   <= F_IDLE;
          end
          default: st_q <= F_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_mmio.sv
module uart_mmio import uart_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int BRG_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_valid_i,
  input  logic        bus_write_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic        rxd_i,
  output logic        txd_o,
  output logic        irq_rx_o,
  output logic        irq_tx_o,
  output logic        irq_fault_o
);
  localparam logic [15:0] MODE_MASK = 16'h8047;
  localparam logic [15:0] STAT_MASK = 16'h9CC0;

  logic [15:0] mode_q, stat_q;
  logic [BRG_W-1:0] brg_q, brg_cnt_q;
  logic oerr_q;

  logic [3:0] reg_idx;
  logic [1:0] reg_op;
  logic wr_en;
  assign reg_idx = bus_addr_i[7:4];
  assign reg_op  = bus_addr_i[3:2];
  assign wr_en   = bus_valid_i && bus_write_i;

  function automatic logic [31:0] apply_op(logic [31:0] cur, logic [31:0] wd, logic [1:0] op);
    unique case (op)
      OP_WR:   return wd;
      OP_CLR:  return cur & ~wd;
      OP_SET:  return cur | wd;
      default: return cur;
    endcase
  endfunction

  logic on_en, loop_en, brk_en, stop2, tx_en, rx_en, tx_isel;
  logic [1:0] rx_isel;
  parity_e par_mode;
  assign on_en    = mode_q[15];
  assign loop_en  = mode_q[6];
  assign stop2    = mode_q[0];
  assign par_mode = parity_e'(mode_q[2:1]);
  assign tx_isel  = stat_q[15];
  assign rx_en    = stat_q[12];
  assign brk_en   = stat_q[11];
  assign tx_en    = stat_q[10];
  assign rx_isel  = stat_q[7:6];

  logic [31:0] stat_cur, stat_new;
  logic oerr_clr, rx_flush;
  assign stat_cur = {16'h0, stat_q | {14'h0, oerr_q, 1'b0}};
  assign stat_new = apply_op(stat_cur, bus_wdata_i, reg_op);
  assign oerr_clr = wr_en && reg_idx == REG_STAT && !stat_new[1];
  assign rx_flush = oerr_clr && oerr_q;

  // baud generator: one tick per 1/16 bit
  logic tick;
  assign tick = on_en && (brg_cnt_q == '0);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brg_cnt_q <= '0;
    else if (!on_en) brg_cnt_q <= '0;
    else if (brg_cnt_q == '0) brg_cnt_q <= brg_q;
    else brg_cnt_q <= brg_cnt_q - 1'b1;
  end

  // transmit path
  logic tx_push, tx_pop, tx_empty, tx_full, tx_ser, tx_busy, trmt;
  logic [7:0] tx_head;
  logic [CW-1:0] tx_count;
  assign tx_push = wr_en && reg_idx == REG_TXD && reg_op == OP_WR;

  uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni, .flush_i(1'b0), .push_i(tx_push), .din_i(bus_wdata_i[7:0]),
    .pop_i(tx_pop), .dout_o(tx_head), .count_o(tx_count),
    .empty_o(tx_empty), .full_o(tx_full));

  uart_tx i_tx (
    .clk_i, .rst_ni, .on_i(on_en), .en_i(tx_en), .tick_i(tick), .par_i(par_mode),
    .stop2_i(stop2), .fifo_empty_i(tx_empty), .fifo_data_i(tx_head),
    .fifo_pop_o(tx_pop), .ser_o(tx_ser), .busy_o(tx_busy));

  logic line_out;
  assign trmt     = tx_empty && !tx_busy;
  assign line_out = brk_en ? 1'b0 : tx_ser;
  assign txd_o    = loop_en ? 1'b1 : line_out;

  // receive path
  logic [1:0] rxd_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rxd_sync_q <= 2'b11;
    else rxd_sync_q <= {rxd_sync_q[0], rxd_i};
  end

  logic rx_done, rx_perr, rx_ferr, rx_pop, rx_empty, rx_full;
  logic [7:0] rx_data;
  logic [9:0] rx_head;
  logic [CW-1:0] rx_count;
  assign rx_pop = bus_valid_i && !bus_write_i && reg_idx == REG_RXD && reg_op == OP_WR;

  uart_rx i_rx (
    .clk_i, .rst_ni, .on_i(on_en), .en_i(rx_en), .tick_i(tick), .par_i(par_mode),
    .ser_i(loop_en ? line_out : rxd_sync_q[1]), .done_o(rx_done), .data_o(rx_data),
    .perr_o(rx_perr), .ferr_o(rx_ferr));

  uart_fifo #(.WIDTH(10), .DEPTH(DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni, .flush_i(rx_flush), .push_i(rx_done), .din_i({rx_perr, rx_ferr, rx_data}),
    .pop_i(rx_pop), .dout_o(rx_head), .count_o(rx_count),
    .empty_o(rx_empty), .full_o(rx_full));

  // register file
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0; stat_q <= '0; brg_q <= '0; oerr_q <= 1'b0;
    end else begin
      if (wr_en && reg_idx == REG_MODE)
        mode_q <= apply_op({16'h0, mode_q}, bus_wdata_i, reg_op)[15:0] & MODE_MASK;
      if (wr_en && reg_idx == REG_STAT)
        stat_q <= stat_new[15:0] & STAT_MASK;
      if (wr_en && reg_idx == REG_BRG)
        brg_q <= apply_op(32'(brg_q), bus_wdata_i, reg_op)[BRG_W-1:0];
      if (oerr_clr) oerr_q <= 1'b0;
      else if (rx_done && rx_full) oerr_q <= 1'b1;
    end
  end

  logic [15:0] stat_rd;
  always_comb begin
    stat_rd    = stat_q & STAT_MASK;
    stat_rd[9] = tx_full;
    stat_rd[8] = trmt;
    stat_rd[3] = !rx_empty && rx_head[9];
    stat_rd[2] = !rx_empty && rx_head[8];
    stat_rd[1] = oerr_q;
    stat_rd[0] = !rx_empty;
  end

  always_comb begin
    unique case (reg_idx)
      REG_MODE: bus_rdata_o = {16'h0, mode_q};
      REG_STAT: bus_rdata_o = {16'h0, stat_rd};
      REG_RXD:  bus_rdata_o = {24'h0, rx_head[7:0]};
      REG_BRG:  bus_rdata_o = 32'(brg_q);
      default:  bus_rdata_o = '0;
    endcase
  end

  // interrupt pulses on rising edge of the selected condition
  logic rx_cond, rx_cond_q, tx_cond, tx_cond_q;
  always_comb begin
    unique case (rx_isel)
      2'b00:   rx_cond = !rx_empty;
      2'b01:   rx_cond = rx_count >= CW'(DEPTH / 2);
      default: rx_cond = rx_full;
    endcase
  end
  assign tx_cond = tx_isel ? !tx_full : trmt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_cond_q <= 1'b0; tx_cond_q <= 1'b1;
    end else begin
      rx_cond_q <= rx_cond; tx_cond_q <= tx_cond;
    end
  end

  assign irq_rx_o    = rx_cond && !rx_cond_q;
  assign irq_tx_o    = tx_cond && !tx_cond_q;
  assign irq_fault_o = rx_done && (rx_perr || rx_ferr || rx_full);

  logic unused_bits;
  assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[31:16]};
endmodule

// File: rtl/uart_mmio_chk.sv
module uart_mmio_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          txd_o,
  input logic          irq_rx_o,
  input logic          loop_en,
  input logic          brk_en,
  input logic          trmt,
  input logic          oerr_q,
  input logic          rx_pop,
  input logic          rx_flush,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count
);
  assert_tx_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_count <= CW'(DEPTH));

  assert_idle_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trmt && !brk_en && !loop_en |-> txd_o);

  assert_rx_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rx_o |=> !irq_rx_o);

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count == CW'(DEPTH) && !rx_pop && !rx_flush |=> rx_count == CW'(DEPTH));

  assert_oerr_when_full_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oerr_q) |-> $past(rx_count) == CW'(DEPTH));

  assert_flush_empty_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oerr_q) |-> rx_count == '0);
endmodule

bind uart_mmio uart_mmio_chk #(.DEPTH(DEPTH)) i_uart_mmio_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .txd_o(txd_o), .irq_rx_o(irq_rx_o),
  .loop_en(loop_en), .brk_en(brk_en), .trmt(trmt), .oerr_q(oerr_q),
  .rx_pop(rx_pop), .rx_flush(rx_flush), .rx_count(rx_count), .tx_count(tx_count));

// File: tb/test_uart_mmio.sv
module test_uart_mmio;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, write = 1'b0, rxd = 1'b1;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic txd, irq_rx, irq_tx, irq_fault;
  int total = 0, bad = 0;
  int n_rx = 0, n_tx = 0, n_fault = 0;
  bit loop_low = 0, mon_loop = 0;

  always #5 clk = ~clk;

  uart_mmio i_uart_mmio (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rxd_i(rxd),
    .txd_o(txd), .irq_rx_o(irq_rx), .irq_tx_o(irq_tx), .irq_fault_o(irq_fault));

  always @(posedge clk) begin
    if (irq_rx) n_rx++;
    if (irq_tx) n_tx++;
    if (irq_fault) n_fault++;
    if (mon_loop && !txd) loop_low = 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); valid = 1; write = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); valid = 1; write = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); valid = 0;
  endtask

  task automatic wait_stat(input int b, input bit v, output bit ok);
    logic [31:0] d;
    ok = 0;
    for (int i = 0; i < 600; i++) begin
      rd(8'h10, d);
      if (d[b] == v) begin ok = 1; break; end
    end
  endtask

  task automatic wait_fall(output bit ok);
    ok = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!txd) begin ok = 1; break; end
    end
  endtask

  // drive one frame on rxd, bit time bc cycles
  task automatic send_rx(input logic [7:0] d, input logic [1:0] par, input bit bad_par,
                         input bit bad_stop, input int bc);
    logic p;
    p = (par == 2'b10) ? ~^d : ^d;
    @(negedge clk); rxd = 0; repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (bc) @(negedge clk); end
    if (par != 2'b00) begin rxd = p ^ bad_par; repeat (bc) @(negedge clk); end
    rxd = !bad_stop; repeat (bc) @(negedge clk);
    rxd = 1; repeat (bc) @(negedge clk);
  endtask

  // check one external frame, bit time bc
  task automatic tx_frame(input logic [7:0] d, input logic [1:0] par, input int bc, input string req);
    bit ok;
    logic [10:0] exp_bits;
    int nb;
    exp_bits = '0;
    exp_bits[8:1] = d;
    nb = 9;
    if (par != 2'b00) begin exp_bits[9] = (par == 2'b10) ? ~^d : ^d; nb = 10; end
    exp_bits[nb] = 1'b1;
    wait_fall(ok);
    check(ok, {req, " start"}, 32'(ok), 1);
    repeat (bc / 2) @(negedge clk);
    for (int i = 0; i <= nb; i++) begin
      check(txd == exp_bits[i], req, 32'(i * 2 + txd), 32'(i * 2 + exp_bits[i]));
      repeat (bc) @(negedge clk);
    end
  endtask

  localparam logic [10:0] VEC [6] = '{
    {2'b00, 1'b0, 8'h55}, {2'b01, 1'b0, 8'hA3}, {2'b10, 1'b1, 8'h00},
    {2'b01, 1'b1, 8'hFF}, {2'b10, 1'b0, 8'h81}, {2'b00, 1'b1, 8'h7E}};

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit ok;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(8'h00, d); check(d == 0, "R1 mode", d, 0);
    rd(8'h10, d); check(d == 32'h100, "R1 status", d, 32'h100);
    rd(8'h40, d); check(d == 0, "R1 divisor", d, 0);
    check(txd == 1, "R1 txd", 32'(txd), 1);

    // R2 write views
    wr(8'h00, 32'h0000_8001);
    wr(8'h08, 32'h0000_0040); rd(8'h00, d); check(d == 32'h8041, "R2 set", d, 32'h8041);
    wr(8'h04, 32'h0000_8000); rd(8'h00, d); check(d == 32'h0041, "R2 clear", d, 32'h41);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check(d == 32'h8047, "R2 mask", d, 32'h8047);
    wr(8'h00, 0);

    // R5 R6 R7 loopback vector table
    wr(8'h40, 0);
    foreach (VEC[k]) begin
      wr(8'h00, 32'h8040 | (32'(VEC[k][10:9]) << 1) | 32'(VEC[k][8]));
      wr(8'h10, 32'h1400);
      loop_low = 0; mon_loop = 1;
      wr(8'h20, 32'(VEC[k][7:0]));
      wait_stat(0, 1, ok);
      check(ok, "R7 loop arrival", 32'(ok), 1);
      rd(8'h10, d); check(d[3:2] == 0, "R5 loop flags", d, 0);
      rd(8'h30, d); check(d == 32'(VEC[k][7:0]), "R7 loop data", d, 32'(VEC[k][7:0]));
      wait_stat(8, 1, ok);
      mon_loop = 0;
      check(!loop_low, "R7 txd idle", 32'(loop_low), 0);
    end

    // R4 R5 external frames, divisor 1 -> 32 cycles per bit
    wr(8'h00, 0);
    wr(8'h40, 1);
    wr(8'h00, 32'h8002); wr(8'h10, 32'h0400);
    wr(8'h20, 32'hA5); tx_frame(8'hA5, 2'b01, 32, "R4 R5 even frame");
    wait_stat(8, 1, ok);
    wr(8'h00, 32'h8004);
    wr(8'h20, 32'h01); tx_frame(8'h01, 2'b10, 32, "R5 odd frame");
    wait_stat(8, 1, ok);

    // R6 stop length
    wr(8'h00, 32'h8001);
    wr(8'h20, 0); wr(8'h20, 0);
    wait_fall(ok); repeat (336) @(negedge clk);
    check(txd == 1, "R6 two stop", 32'(txd), 1);
    wait_stat(8, 1, ok);
    wr(8'h00, 32'h8000);
    wr(8'h20, 0); wr(8'h20, 0);
    wait_fall(ok); repeat (336) @(negedge clk);
    check(txd == 0, "R6 one stop", 32'(txd), 0);
    wait_stat(8, 1, ok);

    // R8 break
    wr(8'h18, 32'h0800); check(txd == 0, "R8 break on", 32'(txd), 0);
    wr(8'h14, 32'h0800); check(txd == 1, "R8 break off", 32'(txd), 1);

    // R9 R10 receive
    wr(8'h00, 32'h8002); wr(8'h10, 32'h1000);
    base = n_rx;
    send_rx(8'h3C, 2'b01, 0, 0, 32);
    check(n_rx - base == 1, "R9 irq_rx", 32'(n_rx - base), 1);
    rd(8'h10, d); check(d[3:0] == 4'b0001, "R9 status", d, 1);
    rd(8'h30, d); check(d == 32'h3C, "R9 data", d, 32'h3C);
    rd(8'h10, d); check(d[0] == 0, "R9 pop", d, 0);
    base = n_fault;
    send_rx(8'h11, 2'b01, 1, 0, 32);
    send_rx(8'h22, 2'b01, 0, 0, 32);
    check(n_fault - base == 1, "R10 fault pulse", 32'(n_fault - base), 1);
    rd(8'h10, d); check(d[3:0] == 4'b1001, "R10 head perr", d, 32'h9);
    rd(8'h30, d); check(d == 32'h11, "R10 data1", d, 32'h11);
    rd(8'h10, d); check(d[3:0] == 4'b0001, "R10 next flags", d, 1);
    rd(8'h30, d); check(d == 32'h22, "R10 data2", d, 32'h22);
    send_rx(8'h44, 2'b01, 0, 1, 32);
    rd(8'h10, d); check(d[3:0] == 4'b0101, "R10 ferr", d, 32'h5);
    rd(8'h30, d);

    // R11 overrun and flush
    base = n_fault;
    for (int i = 0; i < 9; i++) send_rx(8'(i), 2'b01, 0, 0, 32);
    rd(8'h10, d); check(d[1:0] == 2'b11, "R11 overrun", d, 3);
    check(n_fault - base == 1, "R11 fault", 32'(n_fault - base), 1);
    wr(8'h14, 32'h2);
    rd(8'h10, d); check(d[1:0] == 2'b00, "R11 flush", d, 0);

    // R13 receiver disabled
    wr(8'h10, 0);
    send_rx(8'h5A, 2'b01, 0, 0, 32);
    rd(8'h10, d); check(d[0] == 0, "R13 rx off", d, 0);

    // R3 R12 transmit queue depth through loopback
    wr(8'h40, 0);
    wr(8'h00, 32'h8040); wr(8'h10, 32'h1000);
    for (int i = 0; i < 9; i++) wr(8'h20, 32'(i));
    rd(8'h10, d); check(d[9:8] == 2'b10, "R3 full", d, 32'h200);
    base = n_tx;
    wr(8'h10, 32'h1400);
    for (int i = 0; i < 8; i++) begin
      wait_stat(0, 1, ok);
      rd(8'h30, d); check(d == 32'(i), "R3 order", d, 32'(i));
    end
    wait_stat(8, 1, ok);
    repeat (400) @(negedge clk);
    rd(8'h10, d); check(d[0] == 0, "R3 ninth dropped", d, 0);
    check(n_tx - base == 1, "R12 irq_tx", 32'(n_tx - base), 1);

    // R13 disabled port sends nothing
    wr(8'h00, 0); wr(8'h10, 32'h0400);
    wr(8'h20, 32'h00);
    ok = 1;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (!txd) ok = 0; end
    check(ok, "R13 off no tx", 32'(ok), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule